// File: doc/BRIEF.md
# Output Compare Channel with Linked Square-Wave Generation

This block is one timer channel. It watches a shared 16-bit timebase and changes a single output pin when the timebase equals a match time it holds. The host programs the channel through a small register write port. A write to the control register picks one of three ways to produce edges, or turns the channel off.

One-shot mode drives a pulse of programmed length as soon as the host starts it. Delayed mode applies a chosen pin action (drive high, drive low or toggle) when the timebase reaches a host-supplied reference time plus a programmed delay. Continuous mode does nothing until a link pulse arrives from another channel. It then multiplies a period value by a fixed-point ratio in a serial shift-and-add unit to get a half-period offset. After that it toggles the pin every offset ticks for as long as it runs, which gives a 50% duty square wave. Each new match time is the previous match time plus the offset, so the wave never drifts.

Top module: `oc_channel`

## Requirements
- R1: While reset is held and right after it, the pin is low and stays low until the host programs the channel.
- R2: Register map at the write port: address 0 control, 1 delay, 2 reference time, 3 period, 4 ratio. Control fields are mode in bits 1:0 (0 off, 1 one-shot, 2 delayed, 3 continuous), action in bits 3:2 (0 hold, 1 drive high, 2 drive low, 3 toggle) and initial level in bit 4. Every control write ends whatever the channel was doing. In the next cycle the pin shows the initial level, except in one-shot mode.
- R3: In one-shot mode the pin takes the inverse of the initial level in the cycle after the control write. It returns to the initial level after exactly delay clock cycles, that is, one cycle after the timebase equals its value at the write plus delay. After that the channel is idle.
- R4: In delayed mode the pin keeps the initial level until the timebase equals reference plus delay (modulo 2^16). In the following cycle the programmed action is applied once, and the channel goes idle.
- R5: A link pulse starts the channel only while it is in continuous mode and waiting for a link. A link in any other mode, or while the wave is already running, has no effect on the pin.
- R6: The continuous-mode half-period offset is (period × ratio) >> 8, truncated to 16 bits, where ratio is unsigned with 8 fractional bits.
- R7: Once running, the pin toggles every offset clock cycles, so high time and low time are both equal to the offset.
- R8: Between the link and the first toggle the pin holds its initial level for more than offset cycles, because the offset has to be computed first.
- R9: Match times advance by the offset modulo 2^16, so the toggle spacing stays exact when the timebase wraps.
- R10: A control write with mode off during a pulse or a running wave stops it. The pin stays at the initial level, even past match times that were pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tbase | input | 16 | Shared timebase value |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | 16 | Register write data |
| linkIn | input | 1 | Link pulse from another channel |
| pinOut | output | 1 | Compare output pin |

## Verification
The assertions assume that the timebase steps through every value. Matches are found by equality, so a value that is skipped would make the pin look stuck, which the properties would flag. They also assume nonzero delays and offsets, and a reference-plus-delay time that lies ahead of the timebase when delayed mode is armed. The bench keeps within these limits by incrementing the timebase once per clock. It only reloads the timebase while the channel is idle or waiting for a link. It sets each reference time well ahead of the current count and picks period and ratio pairs whose truncated product is nonzero, including one pair that overflows 16 bits.

// File: rtl/oc_pkg.sv
package oc_pkg;

  typedef enum logic [1:0] {
    MODE_OFF     = 2'd0,
    MODE_ONESHOT = 2'd1,
    MODE_DELAYED = 2'd2,
    MODE_CONT    = 2'd3
  } ocMode_e;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_HIGH   = 2'd1,
    ACT_LOW    = 2'd2,
    ACT_TOGGLE = 2'd3
  } ocAct_e;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_ONESHOT  = 3'd1,
    ST_DELAYED  = 3'd2,
    ST_WAITLINK = 3'd3,
    ST_CALC     = 3'd4,
    ST_RUN      = 3'd5
  } ocState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadOneShot;  // match = tbase + delay
    logic loadDelayed;  // match = reference + delay
    logic mulStart;     // begin offset multiply
    logic loadFirst;    // match = tbase + offset
    logic advance;      // match = match + offset
  } ocStrobe_t;

  // register addresses
  localparam int unsigned ADDR_CTRL   = 0;
  localparam int unsigned ADDR_DELAY  = 1;
  localparam int unsigned ADDR_REF    = 2;
  localparam int unsigned ADDR_PERIOD = 3;
  localparam int unsigned ADDR_RATIO  = 4;

  // control field positions
  localparam int unsigned CTRL_W     = 5;
  localparam int unsigned CTRL_MODE  = 0;
  localparam int unsigned CTRL_ACT   = 2;
  localparam int unsigned CTRL_INIT  = 4;

endpackage

// File: rtl/oc_shiftmul.sv
module oc_shiftmul #(
  parameter int unsigned W    = 16,
  parameter int unsigned FRAC = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [W-1:0] multiplicand,
  input  logic [W-1:0] multiplier,
  output logic         done,
  output logic [W-1:0] result
);
  localparam int unsigned AccW = W + FRAC;
  localparam int unsigned CntW = (W > 1) ? $clog2(W) : 1;

  logic [AccW-1:0] acc;
  logic [AccW-1:0] mcand;
  logic [W-1:0]    mplier;
  logic [CntW-1:0] cnt;
  logic            busy;
  logic            doneR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc    <= '0;
      mcand  <= '0;
      mplier <= '0;
      cnt    <= '0;
      busy   <= 1'b0;
      doneR  <= 1'b0;
    end else begin
      doneR <= 1'b0;
      if (start) begin
        acc    <= '0;
        mcand  <= AccW'(multiplicand);
        mplier <= multiplier;
        cnt    <= '0;
        busy   <= 1'b1;
      end else if (busy) begin
        if (mplier[0]) acc <= acc + mcand;
        mcand  <= mcand << 1;
        mplier <= mplier >> 1;
        cnt    <= cnt + 1'b1;
        if (cnt == CntW'(W - 1)) begin
          busy  <= 1'b0;
          doneR <= 1'b1;
        end
      end
    end
  end

  assign done   = doneR;
  assign result = acc[FRAC +: W];

endmodule

// File: rtl/oc_datapath.sv
module oc_datapath
  import oc_pkg::*;
#(
  parameter int unsigned TW   = 16,
  parameter int unsigned FRAC = 8,
  parameter int unsigned AW   = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [TW-1:0] tbase,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [TW-1:0] wrData,
  input  ocStrobe_t     strobe,
  output logic          matchHit,
  output logic          mulDone
);
  localparam int unsigned NPARM = 4;

  logic [TW-1:0] parm [NPARM];
  logic [TW-1:0] matchTime;
  logic [TW-1:0] offset;

  // parameter registers at addresses 1..NPARM
  for (genvar i = 0; i < NPARM; i++) begin : g_parm
    always_ff @(posedge clk) begin
      if (!rstN) parm[i] <= '0;
      else if (wrEn && wrAddr == AW'(i + 1)) parm[i] <= wrData;
    end
  end

  logic [TW-1:0] delayVal, refVal, periodVal, ratioVal;
  assign delayVal  = parm[ADDR_DELAY - 1];
  assign refVal    = parm[ADDR_REF - 1];
  assign periodVal = parm[ADDR_PERIOD - 1];
  assign ratioVal  = parm[ADDR_RATIO - 1];

  oc_shiftmul #(.W(TW), .FRAC(FRAC)) u_mul (
    .clk          (clk),
    .rstN         (rstN),
    .start        (strobe.mulStart),
    .multiplicand (periodVal),
    .multiplier   (ratioVal),
    .done         (mulDone),
    .result       (offset)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchTime <= '0;
    end else begin
      unique case (1'b1)
        strobe.loadOneShot: matchTime <= tbase + delayVal;
        strobe.loadDelayed: matchTime <= refVal + delayVal;
        strobe.loadFirst:   matchTime <= tbase + offset;
        strobe.advance:     matchTime <= matchTime + offset;
        default:            matchTime <= matchTime;
      endcase
    end
  end

  assign matchHit = (tbase == matchTime);

endmodule

// File: rtl/oc_control.sv
module oc_control
  import oc_pkg::*;
#(
  parameter int unsigned AW = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [AW-1:0]     wrAddr,
  input  logic [CTRL_W-1:0] ctrlBits,
  input  logic              linkIn,
  input  logic              matchHit,
  input  logic              mulDone,
  output ocStrobe_t         strobe,
  output logic              pinOut,
  output ocState_e          state
);
  logic     ctrlWr;
  ocMode_e  newMode;
  ocAct_e   act;
  logic     initLvl;
  logic     newInit;

  assign ctrlWr  = wrEn && (wrAddr == AW'(ADDR_CTRL));
  assign newMode = ocMode_e'(ctrlBits[CTRL_MODE +: 2]);
  assign newInit = ctrlBits[CTRL_INIT];

  always_comb begin
    strobe             = '0;
    strobe.loadOneShot = ctrlWr && (newMode == MODE_ONESHOT);
    strobe.loadDelayed = ctrlWr && (newMode == MODE_DELAYED);
    strobe.mulStart    = !ctrlWr && (state == ST_WAITLINK) && linkIn;
    strobe.loadFirst   = !ctrlWr && (state == ST_CALC) && mulDone;
    strobe.advance     = !ctrlWr && (state == ST_RUN) && matchHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pinOut  <= 1'b0;
      act     <= ACT_HOLD;
      initLvl <= 1'b0;
    end else if (ctrlWr) begin
      act     <= ocAct_e'(ctrlBits[CTRL_ACT +: 2]);
      initLvl <= newInit;
      pinOut  <= (newMode == MODE_ONESHOT) ? !newInit : newInit;
      unique case (newMode)
        MODE_OFF:     state <= ST_IDLE;
        MODE_ONESHOT: state <= ST_ONESHOT;
        MODE_DELAYED: state <= ST_DELAYED;
        MODE_CONT:    state <= ST_WAITLINK;
        default:      state <= ST_IDLE;
      endcase
    end else begin
      unique case (state)
        ST_ONESHOT: if (matchHit) begin
          pinOut <= initLvl;
          state  <= ST_IDLE;
        end
        ST_DELAYED: if (matchHit) begin
          unique case (act)
            ACT_HIGH:   pinOut <= 1'b1;
            ACT_LOW:    pinOut <= 1'b0;
            ACT_TOGGLE: pinOut <= !pinOut;
            default:    pinOut <= pinOut;
          endcase
          state <= ST_IDLE;
        end
        ST_WAITLINK: if (linkIn) state <= ST_CALC;
        ST_CALC:     if (mulDone) state <= ST_RUN;
        ST_RUN:      if (matchHit) pinOut <= !pinOut;
        default:     state <= state;
      endcase
    end
  end

endmodule

// File: rtl/oc_channel.sv
module oc_channel
  import oc_pkg::*;
#(
  parameter int unsigned TW   = 16,
  parameter int unsigned FRAC = 8,
  parameter int unsigned AW   = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [TW-1:0] tbase,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [TW-1:0] wrData,
  input  logic          linkIn,
  output logic          pinOut
);
  ocStrobe_t         strobe;
  logic              matchHit;
  logic              mulDone;
  ocState_e          ctlState;
  logic [CTRL_W-1:0] ctrlBits;

  assign ctrlBits = wrData[CTRL_W-1:0];

  oc_control #(.AW(AW)) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .ctrlBits (ctrlBits),
    .linkIn   (linkIn),
    .matchHit (matchHit),
    .mulDone  (mulDone),
    .strobe   (strobe),
    .pinOut   (pinOut),
    .state    (ctlState)
  );

  oc_datapath #(.TW(TW), .FRAC(FRAC), .AW(AW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .tbase    (tbase),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .strobe   (strobe),
    .matchHit (matchHit),
    .mulDone  (mulDone)
  );

endmodule

// File: rtl/oc_channel_chk.sv
module oc_channel_chk
  import oc_pkg::*;
#(
  parameter int unsigned AW = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [AW-1:0]     wrAddr,
  input logic [CTRL_W-1:0] ctrlBits,
  input logic              pinOut,
  input logic              matchHit,
  input ocState_e          ctlState
);
  logic ctrlWr;
  logic isOneShot;
  assign ctrlWr    = wrEn && (wrAddr == AW'(ADDR_CTRL));
  assign isOneShot = (ctrlBits[CTRL_MODE +: 2] == MODE_ONESHOT);

  // R2
  ctrl_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && !isOneShot) |=> (pinOut == $past(ctrlBits[CTRL_INIT])));

  // R3
  oneshot_lead_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && isOneShot) |=> (pinOut != $past(ctrlBits[CTRL_INIT])));

  // R4
  pin_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pinOut != $past(pinOut)) |-> ($past(ctrlWr) || $past(matchHit)));

  // R7
  run_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctlState == ST_RUN && matchHit && !ctrlWr) |=> (pinOut != $past(pinOut)));

  // R8
  startup_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((ctlState == ST_WAITLINK || ctlState == ST_CALC) && !ctrlWr)
      |=> (pinOut == $past(pinOut)));

endmodule

bind oc_channel oc_channel_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrAddr   (wrAddr),
  .ctrlBits (ctrlBits),
  .pinOut   (pinOut),
  .matchHit (matchHit),
  .ctlState (ctlState)
);

// File: tb/oc_channel_tb.sv
module oc_channel_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] tbase = 16'h0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = 3'd0;
  logic [15:0] wrData = 16'h0;
  logic        linkIn = 1'b0;
  logic        pinOut;
  logic        tbLoad = 1'b0;
  logic [15:0] tbLoadVal = 16'h0;
  int          checks = 0;
  int          fails = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  always @(posedge clk) tbase <= tbLoad ? tbLoadVal : tbase + 16'd1;

  oc_channel u_dut (
    .clk(clk), .rstN(rstN), .tbase(tbase), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .linkIn(linkIn), .pinOut(pinOut)
  );

  task automatic checkEq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ctrl(int mode, int act, int init);
    return 16'((init << 4) | (act << 2) | mode);
  endfunction

  task automatic writeReg(int addr, logic [15:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'(addr); wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setTime(logic [15:0] v);
    @(negedge clk); tbLoad = 1'b1; tbLoadVal = v;
    @(negedge clk); tbLoad = 1'b0;
  endtask

  task automatic pulseLink();
    @(negedge clk); linkIn = 1'b1;
    @(negedge clk); linkIn = 1'b0;
  endtask

  task automatic holdCheck(string req, string what, int lvl, int cycles);
    int bad = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (pinOut != lvl) bad++;
    end
    checkEq(req, what, bad, 0);
  endtask

  task automatic testReset();
    holdCheck("R1", "pin low after reset", 0, 20);
  endtask

  task automatic testOneShot(int dly, int init);
    int n = 0;
    writeReg(1, 16'(dly));
    writeReg(0, ctrl(1, 0, init));
    checkEq("R2", "one-shot leading level", pinOut, init ? 0 : 1);
    while (pinOut != init && n < dly + 20) begin n++; @(negedge clk); end
    checkEq("R3", "one-shot width", n, dly);
    holdCheck("R3", "idle after one-shot", init, dly + 10);
  endtask

  task automatic testDelayed(int act, int init, int expLvl);
    logic [15:0] refT, m;
    int bad = 0;
    writeReg(1, 16'd10);
    refT = tbase + 16'd40;
    writeReg(2, refT);
    writeReg(0, ctrl(2, act, init));
    checkEq("R2", "delayed init level", pinOut, init);
    m = refT + 16'd10;
    while (tbase != m) begin
      if (pinOut != init) bad++;
      @(negedge clk);
    end
    if (pinOut != init) bad++;
    checkEq("R4", "no early action", bad, 0);
    @(negedge clk);
    checkEq("R4", "action at match", pinOut, expLvl);
    holdCheck("R4", "single action", expLvl, 30);
  endtask

  task automatic testSquare(logic [15:0] period, logic [15:0] ratio,
                            logic [15:0] startT, int expOff, string req);
    int n = 1;
    setTime(startT);
    writeReg(3, period);
    writeReg(4, ratio);
    writeReg(0, ctrl(3, 0, 0));
    checkEq("R2", "continuous init level", pinOut, 0);
    pulseLink();
    while (pinOut == 0 && n < 70000) begin @(negedge clk); n++; end
    checkEq("R8", "startup longer than offset", (n > expOff) ? 1 : 0, 1);
    for (int k = 0; k < 4; k++) begin
      logic cur = pinOut;
      int c = 1;
      if (k == 2) linkIn = 1'b1;
      @(negedge clk);
      while (pinOut == cur && c < 70000) begin c++; @(negedge clk); end
      linkIn = 1'b0;
      checkEq(k == 2 ? "R5" : req, "half period", c, expOff);
    end
    writeReg(0, ctrl(0, 0, 0));
    checkEq("R10", "stop level", pinOut, 0);
    holdCheck("R10", "stays stopped", 0, 2 * expOff + 5);
  endtask

  task automatic testLinkIgnored();
    writeReg(3, 16'd7);
    writeReg(4, 16'h0140);
    writeReg(0, ctrl(0, 0, 1));
    pulseLink();
    holdCheck("R5", "link ignored when off", 1, 60);
    writeReg(0, ctrl(0, 0, 0));
  endtask

  task automatic testAbortOneShot();
    writeReg(1, 16'd30);
    writeReg(0, ctrl(1, 0, 0));
    checkEq("R3", "abort: pulse started", pinOut, 1);
    repeat (10) @(negedge clk);
    writeReg(0, ctrl(0, 0, 0));
    checkEq("R10", "abort level", pinOut, 0);
    holdCheck("R10", "pending match ignored", 0, 40);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testOneShot(12, 0);
    testOneShot(37, 1);
    testDelayed(1, 0, 1);
    testDelayed(2, 1, 0);
    testDelayed(3, 1, 0);
    testDelayed(0, 0, 0);
    testSquare(16'd7, 16'h0140, 16'h1000, 8, "R6");
    testSquare(16'd100, 16'h0180, 16'hFF80, 150, "R9");
    testSquare(16'h3400, 16'h0500, 16'h2000, 1024, "R7");
    testLinkIgnored();
    testAbortOneShot();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule